// File: doc/BRIEF.md
# Configurable Output Macrocell

This block is one per-pin output cell that sits behind a sum-of-products array. It takes the array's sum term for its pin, an individual output-enable term, and asynchronous preset and reset terms shared across cells. A static configuration selects one of four pin behaviours and a polarity option. The configuration also decides which signal goes back to the array as feedback.

The cell holds one edge-triggered register. An active-low power-up reset clears the register asynchronously. The asynchronous reset and preset terms clear or set it without a clock. A test preload path loads any chosen value on a clock edge, whatever the sum term is. The pin is modelled as a driven value plus a drive enable, with the external pin level brought back in on a separate input.

Top module: `mc_cell`

## Requirements
- R1: Mode encoding on `cfg_mode` is 0 = input-only, 1 = combinational output, 2 = bidirectional, 3 = registered. In input-only mode `pin_oe` is 0. In every other mode `pin_oe` equals `oe_term`.
- R2: In combinational and bidirectional modes, `pin_out` equals `sum_term` XOR `cfg_invert`, with no clock delay.
- R3: On each rising clock edge with no preload and no asynchronous term active, the register takes `sum_term`. In registered mode `pin_out` equals the register XOR `cfg_invert`.
- R4: In registered mode `fb_out` carries the true register value, unaffected by `cfg_invert`.
- R5: In input-only mode `fb_out` equals `pin_in`.
- R6: In bidirectional mode `fb_out` equals `pin_in` while `oe_term` is 0, and equals the driven level `pin_out` while `oe_term` is 1.
- R7: In combinational output mode `fb_out` is 0.
- R8: A high `ar_term` clears the register at once, without waiting for a clock edge.
- R9: A high `ap_term` with `ar_term` low sets the register at once, without waiting for a clock edge.
- R10: When `ap_term` and `ar_term` are both high, the register reads 0.
- R11: A low `rst_n` clears the register asynchronously, so the register reads 0 out of reset.
- R12: On a rising clock edge with `preload_en` high, the register loads `preload_d` and ignores `sum_term`.
- R13: In input-only mode `pin_out` is held at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low power-up reset, asynchronous clear |
| cfg_mode | input | 2 | Pin mode select (see R1) |
| cfg_invert | input | 1 | Invert the level driven to the pin |
| sum_term | input | 1 | OR of the cell's product terms |
| oe_term | input | 1 | Output-enable product term |
| ap_term | input | 1 | Shared asynchronous preset term |
| ar_term | input | 1 | Shared asynchronous reset term |
| preload_en | input | 1 | Test preload enable, sampled on the clock edge |
| preload_d | input | 1 | Test preload value |
| pin_in | input | 1 | Level observed on the external pin |
| pin_out | output | 1 | Level driven toward the pin |
| pin_oe | output | 1 | Pin driver enable |
| fb_out | output | 1 | Feedback into the array |

## Verification
Several rules are checked every cycle by the assertions: the pin driver stays off in input-only mode, and registered feedback differs from the pin level exactly by the polarity bit. Reset wins over preset, preset forces a 1, bidirectional feedback follows the pin while the driver is off, and preload lands on the following edge. The bench scenarios are needed for the behaviour that sits between clock edges or inside reset. This covers the power-up clear, asynchronous set and clear with no clock, and the combinational value of each mode under both polarities. Only the scenarios show these, because the clocked properties are disabled during reset and sample only on edges.

// File: rtl/mc_pkg.sv
package mc_pkg;

    typedef enum logic [1:0] {
        MODE_INPUT = 2'd0,
        MODE_COMB  = 2'd1,
        MODE_BIDIR = 2'd2,
        MODE_REG   = 2'd3
    } pin_mode_e;

    typedef struct packed {
        logic preset;
        logic clear;
    } async_req_t;

    typedef struct packed {
        logic level;
        logic enable;
    } pin_drive_t;

    function automatic logic apply_polarity(input logic val, input logic invert);
        return val ^ invert;
    endfunction

    function automatic logic async_override(input async_req_t req, input logic held);
        if (req.clear)
            return 1'b0;
        else if (req.preset)
            return 1'b1;
        else
            return held;
    endfunction

endpackage

// File: rtl/mc_state_reg.sv
module mc_state_reg
    import mc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  async_req_t async_req,
    input  logic       sum_term,
    input  logic       preload_en,
    input  logic       preload_d,
    output logic       q
);
    logic q_held;
    logic next_d;

    always_comb begin
        next_d = preload_en ? preload_d : sum_term;
    end

    always_ff @(posedge clk or negedge rst_n or posedge async_req.clear or posedge async_req.preset) begin
        if (!rst_n)
            q_held <= 1'b0;
        else if (async_req.clear)
            q_held <= 1'b0;
        else if (async_req.preset)
            q_held <= 1'b1;
        else
            q_held <= next_d;
    end

    always_comb begin
        if (!rst_n)
            q = 1'b0;
        else
            q = async_override(async_req, q_held);
    end
endmodule

// File: rtl/mc_pin_drive.sv
module mc_pin_drive
    import mc_pkg::*;
(
    input  pin_mode_e  mode,
    input  logic       invert,
    input  logic       sum_term,
    input  logic       oe_term,
    input  logic       q,
    output pin_drive_t drive
);
    always_comb begin
        drive.level  = 1'b0;
        drive.enable = 1'b0;
        unique case (mode)
            MODE_INPUT: begin
                drive.level  = 1'b0;
                drive.enable = 1'b0;
            end
            MODE_COMB, MODE_BIDIR: begin
                drive.level  = apply_polarity(sum_term, invert);
                drive.enable = oe_term;
            end
            MODE_REG: begin
                drive.level  = apply_polarity(q, invert);
                drive.enable = oe_term;
            end
            default: begin
                drive.level  = 1'b0;
                drive.enable = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/mc_feedback_sel.sv
module mc_feedback_sel
    import mc_pkg::*;
(
    input  pin_mode_e  mode,
    input  pin_drive_t drive,
    input  logic       pin_in,
    input  logic       q,
    output logic       fb
);
    always_comb begin
        unique case (mode)
            MODE_INPUT: fb = pin_in;
            MODE_COMB:  fb = 1'b0;
            MODE_BIDIR: fb = drive.enable ? drive.level : pin_in;
            MODE_REG:   fb = q;
            default:    fb = 1'b0;
        endcase
    end
endmodule

// File: rtl/mc_cell.sv
module mc_cell
    import mc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cfg_mode,
    input  logic       cfg_invert,
    input  logic       sum_term,
    input  logic       oe_term,
    input  logic       ap_term,
    input  logic       ar_term,
    input  logic       preload_en,
    input  logic       preload_d,
    input  logic       pin_in,
    output logic       pin_out,
    output logic       pin_oe,
    output logic       fb_out
);
    pin_mode_e  mode;
    async_req_t async_req;
    pin_drive_t drive;
    logic       q;

    always_comb begin
        mode            = pin_mode_e'(cfg_mode);
        async_req.clear  = ar_term;
        async_req.preset = ap_term;
    end

    mc_state_reg u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_req  (async_req),
        .sum_term   (sum_term),
        .preload_en (preload_en),
        .preload_d  (preload_d),
        .q          (q)
    );

    mc_pin_drive u_drive (
        .mode     (mode),
        .invert   (cfg_invert),
        .sum_term (sum_term),
        .oe_term  (oe_term),
        .q        (q),
        .drive    (drive)
    );

    mc_feedback_sel u_fb (
        .mode   (mode),
        .drive  (drive),
        .pin_in (pin_in),
        .q      (q),
        .fb     (fb_out)
    );

    assign pin_out = drive.level;
    assign pin_oe  = drive.enable;
endmodule

// File: rtl/mc_cell_chk.sv
module mc_cell_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cfg_mode,
    input logic       cfg_invert,
    input logic       oe_term,
    input logic       ap_term,
    input logic       ar_term,
    input logic       preload_en,
    input logic       preload_d,
    input logic       pin_in,
    input logic       pin_out,
    input logic       pin_oe,
    input logic       fb_out
);
    AST_INPUT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd0) |-> (!pin_oe && !pin_out)); // R1

    AST_REG_FB_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd3) |-> (pin_out == (fb_out ^ cfg_invert))); // R4

    AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd3 && ar_term) |-> (fb_out == 1'b0)); // R10

    AST_PRESET_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd3 && ap_term && !ar_term) |-> (fb_out == 1'b1)); // R9

    AST_BIDIR_PIN_FB: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd2 && !oe_term) |-> (fb_out == pin_in)); // R6

    AST_PRELOAD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd3 && preload_en && !ap_term && !ar_term) |=>
        (cfg_mode != 2'd3 || ap_term || ar_term || fb_out == $past(preload_d))); // R12
endmodule

bind mc_cell mc_cell_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_mode   (cfg_mode),
    .cfg_invert (cfg_invert),
    .oe_term    (oe_term),
    .ap_term    (ap_term),
    .ar_term    (ar_term),
    .preload_en (preload_en),
    .preload_d  (preload_d),
    .pin_in     (pin_in),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .fb_out     (fb_out)
);

// File: tb/mc_cell_bench.sv
`timescale 1ns/1ps
module mc_cell_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] cfg_mode;
    logic       cfg_invert, sum_term, oe_term, ap_term, ar_term;
    logic       preload_en, preload_d, pin_in;
    logic       pin_out, pin_oe, fb_out;
    int         n_checks = 0;
    int         n_fail = 0;
    int         cycles = 0;

    always #2 clk = ~clk;

    mc_cell u_mc_cell (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_invert(cfg_invert),
        .sum_term(sum_term), .oe_term(oe_term), .ap_term(ap_term), .ar_term(ar_term),
        .preload_en(preload_en), .preload_d(preload_d), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out)
    );

    // {mode[1:0], invert, sum, oe, pin_in, exp_out, exp_oe, exp_fb}
    localparam int NVEC = 9;
    localparam logic [8:0] VEC [NVEC] = '{
        9'b00_1_1_1_1_0_0_1, // R1 R5 R13 input-only
        9'b00_1_0_1_0_0_0_0, // R1 R5 R13
        9'b01_0_1_1_0_1_1_0, // R2 R7 comb
        9'b01_1_1_1_1_0_1_0, // R2 R7 inverted
        9'b01_1_0_0_1_1_0_0, // R1 R2 R7 driver off
        9'b10_0_1_0_0_1_0_0, // R6 bidir driver off, pin 0
        9'b10_0_0_0_1_0_0_1, // R6 bidir driver off, pin 1
        9'b10_1_0_1_0_1_1_1, // R2 R6 bidir driven inverted
        9'b10_0_1_1_0_1_1_1  // R6 bidir driven
    };

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; cfg_mode = 2'd3; cfg_invert = 1'b0; sum_term = 1'b1;
        oe_term = 1'b1; ap_term = 1'b0; ar_term = 1'b0;
        preload_en = 1'b0; preload_d = 1'b0; pin_in = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R11 reset state", {pin_out, pin_oe, fb_out}, 3'b010);
        @(negedge clk) rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            {cfg_mode, cfg_invert, sum_term, oe_term, pin_in} = VEC[i][8:3];
            #1;
            check($sformatf("R1/R2/R5/R6/R7/R13 vector %0d", i),
                  {pin_out, pin_oe, fb_out}, VEC[i][2:0]);
        end

        // R3 R4: registered capture and polarity
        @(negedge clk);
        cfg_mode = 2'd3; cfg_invert = 1'b0; oe_term = 1'b1; sum_term = 1'b1;
        @(posedge clk); #1;
        check("R3 capture 1", {pin_out, fb_out}, 2'b11);
        @(negedge clk) cfg_invert = 1'b1; #1;
        check("R4 inverted pin, true feedback", {pin_out, fb_out}, 2'b01);
        @(negedge clk) sum_term = 1'b0;
        @(posedge clk); #1;
        check("R3 capture 0 inverted", {pin_out, fb_out}, 2'b10);
        @(negedge clk) oe_term = 1'b0; #1;
        check("R1 registered enable follows term", {1'b0, pin_oe, 1'b0}, 3'b000);

        // R12: preload ignores sum_term
        @(negedge clk);
        cfg_invert = 1'b0; preload_en = 1'b1; preload_d = 1'b1; sum_term = 1'b0;
        @(posedge clk); #1;
        check("R12 preload 1", {2'b00, fb_out}, 3'b001);
        @(negedge clk) begin preload_d = 1'b0; sum_term = 1'b1; end
        @(posedge clk); #1;
        check("R12 preload 0", {2'b00, fb_out}, 3'b000);
        @(negedge clk) begin preload_en = 1'b0; sum_term = 1'b1; end
        @(posedge clk); #1;
        check("R3 back to sum", {2'b00, fb_out}, 3'b001);

        // R8: asynchronous clear, no clock edge in between
        @(negedge clk) begin sum_term = 1'b1; ar_term = 1'b1; end
        #1;
        check("R8 async clear", {2'b00, fb_out}, 3'b000);
        @(negedge clk) begin ar_term = 1'b0; sum_term = 1'b0; end
        #1;
        check("R8 stays clear", {2'b00, fb_out}, 3'b000);

        // R9: asynchronous set
        @(negedge clk) ap_term = 1'b1;
        #1;
        check("R9 async set", {2'b00, fb_out}, 3'b001);

        // R10: both terms, reset wins
        @(negedge clk) ar_term = 1'b1;
        #1;
        check("R10 clear beats set", {2'b00, fb_out}, 3'b000);
        @(posedge clk); #1;
        check("R10 across edge", {2'b00, fb_out}, 3'b000);
        @(negedge clk) begin ar_term = 1'b0; ap_term = 1'b0; sum_term = 1'b1; end
        @(posedge clk); #1;
        check("R3 reload 1", {2'b00, fb_out}, 3'b001);

        // R11: asynchronous power-up clear between edges
        @(negedge clk) rst_n = 1'b0;
        #1;
        check("R11 async power-up clear", {2'b00, fb_out}, 3'b000);
        @(negedge clk) rst_n = 1'b1;

        finish_run();
    end
endmodule